// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces up to four independent pulse-width-modulated outputs from one source clock. Each channel is steered by a single 32-bit control word that software writes over a plain memory-mapped write/read port. The word carries an enable flag, an 8-bit pulse width and a 13-bit clock-division value. The division value first slows the source clock by a ratio from 1 to 8192. The slowed tick then drives an 8-bit period counter, so one output period always spans 256 ticks. The output is high while the period counter is below the pulse width.

Any write to a channel takes effect at once. The prescaler and the period counter are thrown away and restart from zero, and clearing the enable flag forces the output low without finishing the period in progress. Channels sit 16 bytes apart in the address space. Addresses past the last built channel read as zero and ignore writes.

Top module: `pwm_quad`

## Requirements
- R1: After reset every output is low and every channel word reads as zero, which leaves all channels disabled.
- R2: A channel word holds the division value in bits [12:0], the pulse width in bits [23:16] and the enable flag in bit 31. A read returns the last value written with every other bit forced to zero.
- R3: The channel is selected by address bits [7:4], so channel n sits at byte address n*16. Address bits [3:0] are ignored.
- R4: An address whose channel index is at or above the built channel count reads as zero. A write to such an address changes no channel word and no output.
- R5: With division value s, one output period lasts 256*(s+1) clocks, and the output is high for exactly width*(s+1) clocks of it.
- R6: A pulse width of 0 keeps the output constantly low. A width of 255 keeps it high for 255 of every 256 ticks.
- R7: Writing a word with the enable flag clear drives the output low from the second rising edge after the write cycle, and it stays low. The running period is abandoned.
- R8: A write to a running channel restarts its prescaler and period counter from zero. From the second rising edge after the write the output begins a fresh period: high at once if the width is non-zero, then high for width*(s+1) clocks.
- R9: Each channel's output depends only on its own word. Writing one channel does not disturb the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed channel word |
| bus_addr | input | 8 | Byte address; bits [7:4] select the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed channel (combinational) |
| pwm_out | output | 4 | One registered PWM output per channel |

## Verification
The hardest case to reach from the ports is a rewrite that lands in the middle of a running period, where the output is already low and the counter is far from its wrap point. A run with no restart would keep the output low for about another hundred cycles. The bench first lets a channel run until its counter is well past the pulse width. It then rewrites the identical word and checks that the output rises on the second edge and stays high for exactly one fresh pulse. The disable case is handled the same way: the enable flag is cleared while the output is high, the bench checks that no high sample appears over more than a full period, and then checks that re-enabling starts a complete pulse.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int SCALE_W  = 13;
    localparam int DUTY_W   = 8;
    localparam int DUTY_LSB = 16;
    localparam int EN_BIT   = 31;
    localparam int WORD_W   = 32;

    typedef struct packed {
        logic               en;
        logic [DUTY_W-1:0]  duty;
        logic [SCALE_W-1:0] scale;
    } chan_cfg_t;

    function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.en    = w[EN_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.scale = w[SCALE_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w                        = '0;
        w[EN_BIT]                = c.en;
        w[DUTY_LSB +: DUTY_W]    = c.duty;
        w[SCALE_W-1:0]           = c.scale;
        return w;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output chan_cfg_t           cfg     [NUM_CH],
    output logic [NUM_CH-1:0]   restart
);

    localparam int IDX_W = ADDR_W - 4;

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
        logic      [NUM_CH-1:0] restart;
    } regs_state_t;

    regs_state_t        st_d, st_q;
    logic [IDX_W-1:0]   idx;
    logic               in_range;

    assign idx = addr[ADDR_W-1:4];

    always_comb begin
        in_range = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(c)) in_range = 1'b1;
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.restart = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (we && idx == IDX_W'(c)) begin
                st_d.cfg[c]     = word_to_cfg(wdata);
                st_d.restart[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(c)) rdata = cfg_to_word(st_q.cfg[c]);
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_out
            assign cfg[g] = st_q.cfg[g];
        end
    endgenerate
    assign restart = st_q.restart;

    // R4: a write outside the built channels leaves every word untouched
    a_r4_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_range) |=> $stable(st_q.cfg));

    // R4: reads outside the built channels return zero
    a_r4_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (rdata == '0));

    // R8: each accepted write raises exactly one restart strobe
    a_r8_one_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> ($countones(restart) == 1));

    // R2: unused bits never read back as one
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[EN_BIT-1:DUTY_LSB+DUTY_W] == '0) && (rdata[DUTY_LSB-1:SCALE_W] == '0));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      restart,
    output logic      pwm_o
);

    typedef struct packed {
        logic [SCALE_W-1:0] pre;
        logic [DUTY_W-1:0]  per;
        logic               out;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cfg.en || restart) begin
            st_d.pre = '0;
            st_d.per = '0;
        end else if (st_q.pre == cfg.scale) begin
            st_d.pre = '0;
            st_d.per = st_q.per + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        st_d.out = cfg.en && (st_d.per < cfg.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.out;

    // R7: a disabled channel is low on the next edge
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !pwm_o);

    // R6: zero width never produces a high output
    a_r6_zero_width_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.duty == '0) |=> !pwm_o);

    // R8: a restart strobe clears both counters
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.pre == '0 && st_q.per == '0));

    // R5: the prescaler never passes the division value
    a_r5_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !restart) |-> (st_q.pre <= cfg.scale));

    // R5: the period counter holds between prescaler ticks
    a_r5_per_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !restart && st_q.pre != cfg.scale) |=> $stable(st_q.per));

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t          cfg     [NUM_CH];
    logic [NUM_CH-1:0]  restart;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .cfg     (cfg),
        .restart (restart)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pwm_chan u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .cfg     (cfg[g]),
                .restart (restart[g]),
                .pwm_o   (pwm_out[g])
            );
        end
    endgenerate

endmodule

// File: tb/sim_pwm_quad.sv
module sim_pwm_quad;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_quad u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] mk(input bit en, input int duty, input int scale);
        return {en, 7'b0, 8'(duty), 3'b0, 13'(scale)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // write ends at the negedge after the capture edge; one more negedge reaches the output update
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic count_high(input int ch, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic high_run(input int ch, output int cnt);
        cnt = 0;
        for (int i = 0; i < 600 && pwm_out[ch]; i++) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs", 32'(pwm_out), 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd(8'(c * 16), d);
            chk("R1 word", d, 32'h0);
        end
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(8'h00, 32'h7F00_0000);
        rd(8'h00, d);
        chk("R2 unused bits zero", d, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d);
        chk("R2 fields", d, 32'h80FF_1FFF);
        wr(8'h00, mk(0, 8'h5A, 13'h1234));
        rd(8'h00, d);
        chk("R2 readback", d, 32'h005A_1234);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        wr(8'h2C, mk(0, 8'h33, 13'h0077));
        rd(8'h20, d);
        chk("R3 low bits ignored", d, 32'h0033_0077);
        rd(8'h10, d);
        chk("R3 neighbour unchanged", d, 32'h0);
    endtask

    task automatic t_oob();
        logic [31:0] d;
        wr(8'h50, mk(1, 200, 0));
        rd(8'h50, d);
        chk("R4 oob read zero", d, 32'h0);
        rd(8'hF0, d);
        chk("R4 top read zero", d, 32'h0);
        rd(8'h00, d);
        chk("R4 ch0 unchanged", d, 32'h005A_1234);
        rd(8'h20, d);
        chk("R4 ch2 unchanged", d, 32'h0033_0077);
        chk("R4 outputs unchanged", 32'(pwm_out), 32'h0);
    endtask

    task automatic t_period();
        int n;
        wr(8'h10, mk(1, 64, 0)); settle();
        chk("R8 first sample high", 32'(pwm_out[1]), 32'h1);
        count_high(1, 256, n);
        chk("R5 s=0 width 64", n, 64);
        wr(8'h10, mk(1, 10, 2)); settle();
        count_high(1, 768, n);
        chk("R5 s=2 width 10", n, 30);
        high_run(1, n);
        chk("R5 s=2 high run", n, 30);
    endtask

    task automatic t_extremes();
        int n;
        wr(8'h10, mk(1, 0, 0)); settle();
        count_high(1, 300, n);
        chk("R6 width 0", n, 0);
        wr(8'h10, mk(1, 255, 0)); settle();
        count_high(1, 512, n);
        chk("R6 width 255", n, 510);
    endtask

    task automatic t_disable();
        int n;
        wr(8'h10, mk(1, 200, 0)); settle();
        repeat (20) @(negedge clk);
        chk("R7 high before disable", 32'(pwm_out[1]), 32'h1);
        wr(8'h10, mk(0, 200, 0)); settle();
        count_high(1, 300, n);
        chk("R7 stays low", n, 0);
        wr(8'h10, mk(1, 200, 0)); settle();
        high_run(1, n);
        chk("R7 fresh period after re-enable", n, 200);
    endtask

    task automatic t_restart();
        int n;
        wr(8'h00, mk(1, 100, 0)); settle();
        repeat (150) @(negedge clk);
        chk("R8 low mid-period", 32'(pwm_out[0]), 32'h0);
        wr(8'h00, mk(1, 100, 0)); settle();
        chk("R8 high after rewrite", 32'(pwm_out[0]), 32'h1);
        high_run(0, n);
        chk("R8 full pulse after rewrite", n, 100);
    endtask

    task automatic t_indep();
        int a, b;
        wr(8'h00, mk(1, 40, 0));
        wr(8'h30, mk(1, 200, 0)); settle();
        fork
            count_high(0, 256, a);
            count_high(3, 256, b);
        join
        chk("R9 ch0 width", a, 40);
        chk("R9 ch3 width", b, 200);
        wr(8'h10, mk(0, 0, 0)); settle();
        count_high(0, 256, a);
        chk("R9 ch0 undisturbed", a, 40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_alias();
        t_oob();
        t_period();
        t_extremes();
        t_disable();
        t_restart();
        t_indep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule